// File: doc/BRIEF.md
# Pulse-and-Verify Programming Sequencer

This block drives the write of a memory image into a one-time-programmable word array. A run starts at word zero. For the current word it drives the address and the intended data, waits out a setup gap and fires one program pulse of a fixed cycle count. It then waits out a hold gap and reads the word back once. A word that reads back correctly moves the sequencer to the next address. A word that is still wrong is pulsed again. When the per-word pulse budget runs out, the run ends as a failure. Programming can only clear bits: erased cells read as all ones, so a word whose image needs a 1 where the cell already holds a 0 can never verify.

When the last word has verified, the sequencer drops its mode output. The target then returns to normal operating conditions. After a settle interval the sequencer reads every word again, one per cycle, and compares each one against the source image. The run ends with a one-cycle done strobe that carries either a pass flag or a fail flag. A status register holds the address of the failing word.

The source image is read through an address/data port that answers in the same cycle. The target's read data must also be valid in the same cycle as the address. Supply switching and pulse shaping are left to the target side.

Top module: `otp_prog_seq`

## Requirements
- R1: After reset, done, pass, fail, tgt_pgm, tgt_rd and tgt_hv are low and fail_addr is zero, and they stay that way until start is seen.
- R2: Start in the idle state begins a run at address 0 with tgt_hv high and clears fail_addr to zero; the first pulse of a run targets address 0.
- R3: Before every pulse, address and data are driven with tgt_hv high for exactly SETUP_CYC cycles. After every pulse, exactly HOLD_CYC quiet cycles pass before the read-back. The address does not change while tgt_pgm is high.
- R4: Every program pulse (tgt_pgm high) lasts exactly PULSE_CYC cycles.
- R5: Each pulse is followed by exactly one read-back cycle (tgt_rd high with tgt_hv high) that compares tgt_rdata with the source word. tgt_pgm and tgt_rd are never high together.
- R6: A word that reads back correctly is not pulsed again. The address steps to the next word and the pulse count starts over, so each word gets as many pulses as it needs.
- R7: A word that fails its read-back after the MAX_PULSES-th pulse ends the run with fail, and fail_addr holds that word; no later word is pulsed. A word that verifies on exactly the MAX_PULSES-th pulse counts as programmed.
- R8: After the last word verifies, tgt_hv goes low and stays low. After SETTLE_CYC cycles, the compare pass reads the addresses 0, 1, 2, ... in consecutive cycles with tgt_rd high, and tgt_pgm stays low.
- R9: In the compare pass, the first mismatching word ends the run with fail and its address in fail_addr. If every word matches, the run ends with pass.
- R10: done is high for exactly one cycle per run, and exactly one of pass and fail is high with it. pass and fail are never high without done.
- R11: Start is ignored while a run is in progress; the run's result and duration are unchanged.
- R12: From the start edge to done, a run takes K*(SETUP_CYC+PULSE_CYC+HOLD_CYC+1) cycles for K pulses in total. A run that reaches the compare pass adds SETTLE_CYC plus the number of words compared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (taken only when idle) |
| done | output | 1 | One-cycle end-of-run strobe |
| pass | output | 1 | High with done when the run succeeded |
| fail | output | 1 | High with done when the run failed |
| fail_addr | output | ADDR_W | Address of the failing word, zero after start |
| src_addr | output | ADDR_W | Source image word address |
| src_data | input | DATA_W | Source image word, valid in the same cycle |
| tgt_addr | output | ADDR_W | Target array word address |
| tgt_wdata | output | DATA_W | Data to be programmed |
| tgt_pgm | output | 1 | Program pulse |
| tgt_rd | output | 1 | Read-back / compare strobe |
| tgt_rdata | input | DATA_W | Target word read data, valid in the same cycle |
| tgt_hv | output | 1 | High: program conditions; low: normal conditions |

## Verification
Every phase has a fixed length, so each result has a known due time. The pulse edges fall SETUP_CYC cycles after the address is driven and end PULSE_CYC cycles later. The read-back comes HOLD_CYC cycles after the pulse ends. The first compare read comes SETTLE_CYC cycles after tgt_hv falls. done rises at the cycle count R12 gives for the pulses the bench's target model will need. The bench predicts that count from the pulse budget of each word. It samples on the falling clock edge and counts rising edges from the start edge, so it checks the exact cycle of done and not just that done eventually arrives. It also checks that done has dropped one cycle later.

// File: rtl/otp_prog_pkg.sv
// Package: shared types for the pulse-and-verify programming sequencer.
// Assumes nothing beyond IEEE 1800-2017 enums.
package otp_prog_pkg;

    // Sequencer phases; program phase first, then compare phase, then report.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_PULSE  = 3'd2,
        ST_HOLD   = 3'd3,
        ST_VERIFY = 3'd4,
        ST_SETTLE = 3'd5,
        ST_CMP    = 3'd6,
        ST_REPORT = 3'd7
    } seq_state_t;

endpackage

// File: rtl/otp_interval_timer.sv
// Module: otp_interval_timer
// Counts down a phase length. A restart loads len-1, so a phase that is
// entered together with the restart lasts exactly len cycles, ending in
// the cycle where expired is high. Assumes len >= 1 at every restart.
module otp_interval_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] len,
    output logic             expired
);

    logic [CNT_W-1:0] remain_q;

    // Load on restart, otherwise count down and rest at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (restart) begin
            remain_q <= len - CNT_W'(1);
        end else if (remain_q != '0) begin
            remain_q <= remain_q - CNT_W'(1);
        end
    end

    assign expired = (remain_q == '0);

endmodule

// File: rtl/otp_retry_counter.sv
// Module: otp_retry_counter
// Counts program pulses fired at the current word and flags when the
// per-word budget is used up. Saturates at the budget. Assumes LIMIT >= 1.
module otp_retry_counter #(
    parameter int LIMIT = 25,
    localparam int RC_W = $clog2(LIMIT + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            bump,
    output logic [RC_W-1:0] count,
    output logic            at_limit
);

    logic [RC_W-1:0] count_q;

    // Clear has priority over bump; bump stops at the budget.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear) begin
            count_q <= '0;
        end else if (bump && (count_q != RC_W'(LIMIT))) begin
            count_q <= count_q + RC_W'(1);
        end
    end

    assign count    = count_q;
    assign at_limit = (count_q == RC_W'(LIMIT));

endmodule

// File: rtl/otp_addr_stepper.sv
// Module: otp_addr_stepper
// Holds the current word address for both passes. Clear returns to word
// zero; step moves to the next word. Assumes step is never asked at the
// last word (the sequencer leaves the pass there instead).
module otp_addr_stepper #(
    parameter int WORDS  = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              is_last
);

    logic [ADDR_W-1:0] addr_q;

    // Address register: clear wins over step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (clear) begin
            addr_q <= '0;
        end else if (step) begin
            addr_q <= addr_q + ADDR_W'(1);
        end
    end

    assign addr    = addr_q;
    assign is_last = (addr_q == ADDR_W'(WORDS - 1));

endmodule

// File: rtl/otp_word_check.sv
// Module: otp_word_check
// Compares a read-back word with the source word. Split into lanes of
// LANE_W bits (generate), each lane giving its own equal flag, so a wide
// word reduces through a shallow AND tree. Assumes DATA_W >= 1.
module otp_word_check #(
    parameter int DATA_W = 16,
    parameter int LANE_W = 8,
    localparam int LANES = (DATA_W + LANE_W - 1) / LANE_W
) (
    input  logic [DATA_W-1:0] expect_word,
    input  logic [DATA_W-1:0] got_word,
    output logic              match
);

    logic [LANES-1:0] lane_eq;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LO = g * LANE_W;
        localparam int HI = ((LO + LANE_W) > DATA_W) ? DATA_W - 1 : LO + LANE_W - 1;
        // Per-lane equality.
        assign lane_eq[g] = (expect_word[HI:LO] == got_word[HI:LO]);
    end

    assign match = &lane_eq;

endmodule

// File: rtl/otp_prog_seq.sv
// Module: otp_prog_seq (top)
// Pulse-and-verify programming sequencer. Program pass: for each word from
// zero, setup gap, one pulse, hold gap, one read-back; retry up to
// MAX_PULSES times. Compare pass: mode output low, settle, read every word
// once per cycle. Ends with a one-cycle done carrying pass or fail.
// Assumes src_data and tgt_rdata answer combinationally to their address
// in the same cycle, and every *_CYC parameter is at least 1.
module otp_prog_seq
    import otp_prog_pkg::*;
#(
    parameter int WORDS      = 8,
    parameter int DATA_W     = 16,
    parameter int PULSE_CYC  = 16,
    parameter int SETUP_CYC  = 2,
    parameter int HOLD_CYC   = 2,
    parameter int SETTLE_CYC = 3,
    parameter int MAX_PULSES = 25,
    localparam int ADDR_W    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              done,
    output logic              pass,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [ADDR_W-1:0] src_addr,
    input  logic [DATA_W-1:0] src_data,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [DATA_W-1:0] tgt_wdata,
    output logic              tgt_pgm,
    output logic              tgt_rd,
    input  logic [DATA_W-1:0] tgt_rdata,
    output logic              tgt_hv
);

    localparam int LEN_A   = (PULSE_CYC > SETUP_CYC) ? PULSE_CYC : SETUP_CYC;
    localparam int LEN_B   = (HOLD_CYC > SETTLE_CYC) ? HOLD_CYC : SETTLE_CYC;
    localparam int LONGEST = (LEN_A > LEN_B) ? LEN_A : LEN_B;
    localparam int CNT_W   = $clog2(LONGEST + 1);
    localparam int RC_W    = $clog2(MAX_PULSES + 1);

    seq_state_t state_q, state_d;

    logic              t_restart;
    logic [CNT_W-1:0]  t_len;
    logic              t_expired;
    logic              a_clear, a_step, a_last;
    logic [ADDR_W-1:0] addr;
    logic              r_clear, r_bump, r_at_limit;
    logic [RC_W-1:0]   r_count;
    logic              word_ok;
    logic              set_ok, set_fail, clr_result;
    logic              ok_q;
    logic [ADDR_W-1:0] fail_addr_q;

    otp_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (t_restart),
        .len     (t_len),
        .expired (t_expired)
    );

    otp_retry_counter #(.LIMIT(MAX_PULSES)) u_retry (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (r_clear),
        .bump     (r_bump),
        .count    (r_count),
        .at_limit (r_at_limit)
    );

    otp_addr_stepper #(.WORDS(WORDS), .ADDR_W(ADDR_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (a_clear),
        .step    (a_step),
        .addr    (addr),
        .is_last (a_last)
    );

    otp_word_check #(.DATA_W(DATA_W)) u_check (
        .expect_word (src_data),
        .got_word    (tgt_rdata),
        .match       (word_ok)
    );

    // Phase transitions and the one-cycle controls for the helpers.
    always_comb begin
        state_d    = state_q;
        t_restart  = 1'b0;
        t_len      = CNT_W'(1);
        a_clear    = 1'b0;
        a_step     = 1'b0;
        r_clear    = 1'b0;
        r_bump     = 1'b0;
        set_ok     = 1'b0;
        set_fail   = 1'b0;
        clr_result = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d    = ST_SETUP;
                    t_restart  = 1'b1;
                    t_len      = CNT_W'(SETUP_CYC);
                    a_clear    = 1'b1;
                    r_clear    = 1'b1;
                    clr_result = 1'b1;
                end
            end
            ST_SETUP: begin
                if (t_expired) begin
                    state_d   = ST_PULSE;
                    t_restart = 1'b1;
                    t_len     = CNT_W'(PULSE_CYC);
                    r_bump    = 1'b1;
                end
            end
            ST_PULSE: begin
                if (t_expired) begin
                    state_d   = ST_HOLD;
                    t_restart = 1'b1;
                    t_len     = CNT_W'(HOLD_CYC);
                end
            end
            ST_HOLD: begin
                if (t_expired) begin
                    state_d = ST_VERIFY;
                end
            end
            ST_VERIFY: begin
                if (word_ok) begin
                    if (a_last) begin
                        state_d   = ST_SETTLE;
                        t_restart = 1'b1;
                        t_len     = CNT_W'(SETTLE_CYC);
                        a_clear   = 1'b1;
                    end else begin
                        state_d   = ST_SETUP;
                        t_restart = 1'b1;
                        t_len     = CNT_W'(SETUP_CYC);
                        a_step    = 1'b1;
                        r_clear   = 1'b1;
                    end
                end else if (r_at_limit) begin
                    state_d  = ST_REPORT;
                    set_fail = 1'b1;
                end else begin
                    state_d   = ST_SETUP;
                    t_restart = 1'b1;
                    t_len     = CNT_W'(SETUP_CYC);
                end
            end
            ST_SETTLE: begin
                if (t_expired) begin
                    state_d = ST_CMP;
                end
            end
            ST_CMP: begin
                if (!word_ok) begin
                    state_d  = ST_REPORT;
                    set_fail = 1'b1;
                end else if (a_last) begin
                    state_d = ST_REPORT;
                    set_ok  = 1'b1;
                end else begin
                    a_step = 1'b1;
                end
            end
            ST_REPORT: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Run result and failing-address status register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok_q        <= 1'b0;
            fail_addr_q <= '0;
        end else if (clr_result) begin
            ok_q        <= 1'b0;
            fail_addr_q <= '0;
        end else if (set_fail) begin
            ok_q        <= 1'b0;
            fail_addr_q <= addr;
        end else if (set_ok) begin
            ok_q <= 1'b1;
        end
    end

    assign done      = (state_q == ST_REPORT);
    assign pass      = done && ok_q;
    assign fail      = done && !ok_q;
    assign fail_addr = fail_addr_q;

    assign src_addr  = addr;
    assign tgt_addr  = addr;
    assign tgt_wdata = src_data;
    assign tgt_pgm   = (state_q == ST_PULSE);
    assign tgt_rd    = (state_q == ST_VERIFY) || (state_q == ST_CMP);
    assign tgt_hv    = (state_q == ST_SETUP) || (state_q == ST_PULSE) ||
                       (state_q == ST_HOLD)  || (state_q == ST_VERIFY);

endmodule

// File: rtl/otp_prog_seq_chk.sv
// Module: otp_prog_seq_chk
// Port-level checker for otp_prog_seq, attached by bind. Pulse width and
// setup age are tracked with counters here, not with long $past windows.
module otp_prog_seq_chk #(
    parameter int PULSE_CYC = 16,
    parameter int SETUP_CYC = 2,
    parameter int ADDR_W    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              pass,
    input logic              fail,
    input logic              tgt_pgm,
    input logic              tgt_rd,
    input logic              tgt_hv,
    input logic [ADDR_W-1:0] tgt_addr
);

    logic [31:0]       pw_cnt;
    logic [31:0]       addr_age;
    logic [ADDR_W-1:0] addr_q;

    // Length of the pulse in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pw_cnt <= '0;
        end else if (tgt_pgm) begin
            pw_cnt <= pw_cnt + 32'd1;
        end else begin
            pw_cnt <= '0;
        end
    end

    // Cycles the address has been unchanged (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_age <= '0;
            addr_q   <= '0;
        end else begin
            addr_q <= tgt_addr;
            if (tgt_addr != addr_q) begin
                addr_age <= '0;
            end else if (addr_age != 32'hFFFF) begin
                addr_age <= addr_age + 32'd1;
            end
        end
    end

    assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tgt_pgm) |-> (pw_cnt == 32'(PULSE_CYC)));

    assert_setup_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tgt_pgm) |-> (addr_age >= 32'(SETUP_CYC - 1)));

    assert_addr_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_pgm && $past(tgt_pgm)) |-> $stable(tgt_addr));

    assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_pgm |-> !tgt_rd);

    assert_pulse_in_hv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_pgm |-> tgt_hv);

    assert_one_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pass != fail));

    assert_flag_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pass || fail) |-> done);

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind otp_prog_seq otp_prog_seq_chk #(
    .PULSE_CYC (PULSE_CYC),
    .SETUP_CYC (SETUP_CYC),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .pass     (pass),
    .fail     (fail),
    .tgt_pgm  (tgt_pgm),
    .tgt_rd   (tgt_rd),
    .tgt_hv   (tgt_hv),
    .tgt_addr (tgt_addr)
);

// File: tb/otp_prog_seq_tb.sv
// Directed bench for otp_prog_seq with a behavioural target array model.
module otp_prog_seq_tb;

    localparam int WORDS  = 8;
    localparam int DATA_W = 16;
    localparam int PW     = 16;
    localparam int SU     = 2;
    localparam int HO     = 2;
    localparam int ST     = 3;
    localparam int MAXP   = 25;
    localparam int AW     = 3;
    localparam int BEAT   = SU + PW + HO + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              done, pass, fail;
    logic [AW-1:0]     fail_addr, src_addr, tgt_addr;
    logic [DATA_W-1:0] src_data, tgt_wdata, tgt_rdata;
    logic              tgt_pgm, tgt_rd, tgt_hv;

    logic [DATA_W-1:0] src  [WORDS];
    logic [DATA_W-1:0] mem  [WORDS];
    int                hard [WORDS];
    int                seen [WORDS];
    int                decay_addr = -1;

    int checks = 0;
    int errors = 0;

    // Monitor state
    int            pw = 0, quiet = 0, settle = 0;
    int            width_bad = 0, gap_bad = 0, settle_bad = 0;
    int            vcnt = 0, pcnt = 0, cmp_n = 0, cmp_bad = 0, first_pa = -1;
    logic          pgm_q = 1'b0;
    logic [AW-1:0] a_q = '0;
    logic [DATA_W-1:0] wd_q = '0;

    always #5 clk = ~clk;

    assign src_data  = src[src_addr];
    assign tgt_rdata = (!tgt_hv && (int'(tgt_addr) == decay_addr)) ?
                       (mem[tgt_addr] ^ 16'h0100) : mem[tgt_addr];

    otp_prog_seq #(
        .WORDS(WORDS), .DATA_W(DATA_W), .PULSE_CYC(PW), .SETUP_CYC(SU),
        .HOLD_CYC(HO), .SETTLE_CYC(ST), .MAX_PULSES(MAXP)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done), .pass(pass),
        .fail(fail), .fail_addr(fail_addr), .src_addr(src_addr),
        .src_data(src_data), .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata),
        .tgt_pgm(tgt_pgm), .tgt_rd(tgt_rd), .tgt_rdata(tgt_rdata),
        .tgt_hv(tgt_hv)
    );

    // Target model and protocol monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (tgt_pgm) begin
                if (!pgm_q) begin
                    if (quiet != SU) gap_bad++;
                    if (first_pa < 0) first_pa = int'(tgt_addr);
                    pcnt++;
                end else if (tgt_addr != a_q) begin
                    gap_bad++;
                end
                pw++;
            end
            if (!tgt_pgm && pgm_q) begin
                if (pw != PW) width_bad++;
                pw = 0;
                seen[a_q]++;
                if (seen[a_q] >= hard[a_q]) mem[a_q] = mem[a_q] & wd_q;
            end
            if (tgt_rd && tgt_hv) begin
                if (quiet != HO) gap_bad++;
                vcnt++;
            end
            if (tgt_rd && !tgt_hv) begin
                if (cmp_n == 0 && settle != ST) settle_bad++;
                if (int'(tgt_addr) != cmp_n) cmp_bad++;
                cmp_n++;
            end
            if (!tgt_hv && tgt_pgm) gap_bad++;
            quiet  = (tgt_hv && !tgt_pgm && !tgt_rd) ? quiet + 1 : 0;
            settle = tgt_hv ? 0 : settle + 1;
            pgm_q  = tgt_pgm;
            a_q    = tgt_addr;
            wd_q   = tgt_wdata;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reset the target and the monitor; called right after a rising edge.
    task automatic prepare(input int seed);
        for (int i = 0; i < WORDS; i++) begin
            src[i]  = DATA_W'((seed * 16'h2F1B) ^ (i * 16'h1357) ^ (16'h8000 >> i));
            mem[i]  = '1;
            hard[i] = 1;
            seen[i] = 0;
        end
        decay_addr = -1;
        width_bad = 0; gap_bad = 0; settle_bad = 0;
        vcnt = 0; pcnt = 0; cmp_n = 0; cmp_bad = 0; first_pa = -1;
        quiet = 0; settle = 0; pw = 0;
    endtask

    // Start a run and wait for done; checks result, status and exact latency.
    task automatic run_seq(input string tag, input bit exp_ok, input int exp_fa,
                           input int exp_lat, input int poke_at);
        int n;
        n = 0;
        @(negedge clk); start = 1'b1;
        @(posedge clk);
        @(negedge clk); start = 1'b0;
        while (!done && n < 50000) begin
            start = (n == poke_at);
            @(posedge clk); n++;
            @(negedge clk);
        end
        start = 1'b0;
        check("R10", {tag, " done"}, int'(done), 1);
        check(exp_ok ? "R9" : "R7", {tag, " pass"}, int'(pass), int'(exp_ok));
        check("R10", {tag, " fail"}, int'(fail), int'(!exp_ok));
        check(exp_ok ? "R9" : "R7", {tag, " fail_addr"}, int'(fail_addr), exp_fa);
        check("R12", {tag, " latency"}, n, exp_lat);
        @(negedge clk);
        check("R10", {tag, " done one cycle"}, int'(done || pass || fail), 0);
    endtask

    task automatic check_protocol(input string tag, input int exp_pulses, input int exp_cmp);
        check("R2", {tag, " first pulse addr"}, first_pa, 0);
        check("R3", {tag, " setup/hold gaps"}, gap_bad, 0);
        check("R4", {tag, " pulse widths"}, width_bad, 0);
        check("R5", {tag, " verifies per pulse"}, vcnt, exp_pulses);
        check("R8", {tag, " settle gap"}, settle_bad, 0);
        check("R8", {tag, " compare order"}, cmp_bad, 0);
        check("R8", {tag, " compare reads"}, cmp_n, exp_cmp);
        check("R12", {tag, " pulse total"}, pcnt, exp_pulses);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1", "idle outputs", int'({done, pass, fail, tgt_pgm, tgt_rd, tgt_hv}), 0);
        check("R1", "fail_addr reset", int'(fail_addr), 0);
    endtask

    task automatic t_clean_pass;
        int bad;
        @(posedge clk); prepare(1);
        run_seq("clean", 1'b1, 0, WORDS * BEAT + ST + WORDS, -1);
        check_protocol("clean", WORDS, WORDS);
        bad = 0;
        for (int i = 0; i < WORDS; i++) if (mem[i] != src[i] || seen[i] != 1) bad++;
        check("R6", "clean words written once", bad, 0);
    endtask

    task automatic t_retries;
        int k, bad;
        @(posedge clk); prepare(2);
        hard[0] = 1; hard[1] = 3; hard[2] = 1; hard[3] = MAXP;
        hard[4] = 2; hard[5] = 1; hard[6] = 1; hard[7] = 4;
        k = 0;
        for (int i = 0; i < WORDS; i++) k += hard[i];
        run_seq("retry", 1'b1, 0, k * BEAT + ST + WORDS, -1);
        check_protocol("retry", k, WORDS);
        bad = 0;
        for (int i = 0; i < WORDS; i++) if (seen[i] != hard[i]) bad++;
        check("R6", "retry pulses per word", bad, 0);
        check("R7", "word verified on last allowed pulse", seen[3], MAXP);
    endtask

    task automatic t_prog_fail;
        @(posedge clk); prepare(3);
        src[2]    = src[2] | 16'h0001;
        mem[2]    = 16'hFFFE;
        run_seq("progfail", 1'b0, 2, (2 + MAXP) * BEAT, -1);
        check("R7", "pulses on failing word", seen[2], MAXP);
        check("R7", "no pulse after failure", seen[3], 0);
        check("R8", "no compare after program failure", cmp_n, 0);
    endtask

    task automatic t_cmp_fail;
        @(posedge clk); prepare(4);
        decay_addr = 3;
        run_seq("cmpfail", 1'b0, 3, WORDS * BEAT + ST + 4, -1);
        check_protocol("cmpfail", WORDS, 4);
    endtask

    task automatic t_busy_start;
        @(posedge clk); prepare(5);
        run_seq("busy", 1'b1, 0, WORDS * BEAT + ST + WORDS, 30);
        check_protocol("busy", WORDS, WORDS);
        check("R11", "start mid-run pulse count", pcnt, WORDS);
        check("R2", "fail_addr cleared by new run", int'(fail_addr), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R12 watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_clean_pass();
        t_retries();
        t_prog_fail();
        t_cmp_fail();
        t_busy_start();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule